// File: doc/BRIEF.md
# Video Letterbox Window Masker

This block sits in a pixel stream and blanks everything outside a programmable rectangle. Pixels inside the rectangle leave untouched. Every pixel outside it is replaced by a constant fill colour. Input and output are AXI4-Stream video carrying one pixel per beat. TUSER marks start of frame and TLAST marks end of line.

Software loads the frame size, the window bounds, the colour format and the three fill components on static inputs, then pulses `start_i`. The block takes a snapshot of those values and processes exactly one frame. It pulses `done_o` once the final pixel has left the output.

The fill components are interpreted through the format select. The same three values can therefore describe a luma/chroma colour or a red/green/blue colour.

Top module: `lbox_mask`

## Requirements
- R1: After reset, `m_tvalid_o`, `s_tready_o` and `done_o` are all 0.
- R2: `s_tready_o` stays 0 until `start_i` arms a frame. It returns to 0 once the frame's final input pixel has been accepted. A `start_i` pulse while a frame is in progress is ignored.
- R3: A pixel at column c and row r is passed unchanged when all of these hold: col_lo <= c < col_hi, c < frame width, and row_lo <= r < row_hi.
- R4: A pixel that fails any condition of R3 is replaced by the fill colour.
- R5: TDATA holds three 8-bit channels: ch0 = bits [7:0], ch1 = bits [15:8], ch2 = bits [23:16]. The format select works as follows:
  - `fmt_i` = 0 selects RGB. The fill is ch2 = fill_a (R), ch1 = fill_c (B), ch0 = fill_b (G).
  - Any other `fmt_i` value selects YCbCr. The fill is ch0 = fill_a (Y), ch1 = fill_b (Cb), ch2 = fill_c (Cr).
  - Each channel takes the low 8 bits of its 16-bit component.
- R6: TUSER and TLAST reach the output unchanged, and the pixel order is preserved. While `m_tready_i` is low, a valid output beat holds its data and sideband steady. No pixel is lost or duplicated.
- R7: A beat with TUSER set is at column 0, row 0. A beat with TLAST set ends its row: the next beat is at column 0 of the following row.
- R8: All configuration inputs are sampled when `start_i` is accepted. Changing them during the frame has no effect on that frame.
- R9: `done_o` is high for exactly one cycle. That cycle is the one right after the output handshake of the beat that has TLAST set on row `frame_h_i`-1.
- R10: An empty or inverted window (start >= end on either axis) fills the whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse that arms one frame |
| done_o | output | 1 | One-cycle frame completion pulse |
| frame_w_i | input | 16 | Frame width in pixels |
| frame_h_i | input | 16 | Frame height in rows |
| fmt_i | input | 16 | Colour format select (0 = RGB, otherwise YCbCr) |
| col_lo_i | input | 16 | First kept column |
| col_hi_i | input | 16 | Column bound, exclusive |
| row_lo_i | input | 16 | First kept row |
| row_hi_i | input | 16 | Row bound, exclusive |
| fill_a_i | input | 16 | Fill component Y or R |
| fill_b_i | input | 16 | Fill component Cb or G |
| fill_c_i | input | 16 | Fill component Cr or B |
| s_tdata_i | input | 24 | Input pixel |
| s_tuser_i | input | 1 | Input start of frame |
| s_tlast_i | input | 1 | Input end of line |
| s_tvalid_i | input | 1 | Input valid |
| s_tready_o | output | 1 | Input ready |
| m_tdata_o | output | 24 | Output pixel |
| m_tuser_o | output | 1 | Output start of frame |
| m_tlast_o | output | 1 | Output end of line |
| m_tvalid_o | output | 1 | Output valid |
| m_tready_i | input | 1 | Output ready |

## Verification
The scoreboard runs several frame patterns, and each one isolates a different part of the masking rule:
- A window strictly inside an 8x6 frame in RGB shows whether the keep test uses inclusive starts and exclusive ends on both axes.
- The same frame in YCbCr under pseudo-random output stalls separates the two channel mappings and exposes dropped or repeated beats.
- An inverted window must blank every pixel.
- Lines longer than the configured width must blank their tail columns.
- A frame whose configuration changes after the first line shows whether the snapshot is kept.
- A second TUSER in the middle of a frame shows whether the counters restart there.

// File: rtl/lbox_pkg.sv
package lbox_pkg;
  localparam int unsigned CFG_W = 16;

  typedef struct packed {
    logic [CFG_W-1:0] width;
    logic [CFG_W-1:0] height;
    logic [CFG_W-1:0] fmt;
    logic [CFG_W-1:0] col_lo;
    logic [CFG_W-1:0] col_hi;
    logic [CFG_W-1:0] row_lo;
    logic [CFG_W-1:0] row_hi;
    logic [CFG_W-1:0] fill_a;
    logic [CFG_W-1:0] fill_b;
    logic [CFG_W-1:0] fill_c;
  } lbox_cfg_t;

  localparam int unsigned NUM_CH = 3;
endpackage

// File: rtl/lbox_cfg_latch.sv
module lbox_cfg_latch
  import lbox_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      load_i,
  input  lbox_cfg_t cfg_i,
  output lbox_cfg_t cfg_o
);
  lbox_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (load_i) cfg_q <= cfg_i;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/lbox_pos_ctr.sv
module lbox_pos_ctr #(
  parameter int unsigned DIM_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             sof_i,
  input  logic             eol_i,
  input  logic [DIM_W-1:0] height_i,
  output logic [DIM_W-1:0] col_o,
  output logic [DIM_W-1:0] row_o,
  output logic             frame_end_o
);
  logic [DIM_W-1:0] col_q, row_q;

  // position of the beat currently offered; SOF forces origin
  assign col_o       = sof_i ? '0 : col_q;
  assign row_o       = sof_i ? '0 : row_q;
  assign frame_end_o = eol_i && (row_o == height_i - DIM_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= '0;
    end else if (step_i) begin
      if (eol_i) begin
        col_q <= '0;
        row_q <= row_o + DIM_W'(1);
      end else begin
        col_q <= col_o + DIM_W'(1);
        row_q <= row_o;
      end
    end
  end
endmodule

// File: rtl/lbox_pix_sel.sv
module lbox_pix_sel
  import lbox_pkg::*;
#(
  parameter int unsigned CH_W  = 8,
  parameter int unsigned DIM_W = 16
) (
  input  lbox_cfg_t             cfg_i,
  input  logic [DIM_W-1:0]      col_i,
  input  logic [DIM_W-1:0]      row_i,
  input  logic [NUM_CH*CH_W-1:0] pix_i,
  output logic [NUM_CH*CH_W-1:0] pix_o
);
  localparam int unsigned PIX_W = NUM_CH * CH_W;

  logic             in_col, in_row, is_rgb;
  logic [CH_W-1:0]  comp [NUM_CH];
  logic [PIX_W-1:0] fill;

  assign in_col = (col_i >= cfg_i.col_lo) && (col_i < cfg_i.col_hi) && (col_i < cfg_i.width);
  assign in_row = (row_i >= cfg_i.row_lo) && (row_i < cfg_i.row_hi);
  assign is_rgb = (cfg_i.fmt == '0);

  assign comp[0] = cfg_i.fill_a[CH_W-1:0];
  assign comp[1] = cfg_i.fill_b[CH_W-1:0];
  assign comp[2] = cfg_i.fill_c[CH_W-1:0];

  // rgb: ch0=G ch1=B ch2=R ; ycc: ch k = component k
  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    assign fill[k*CH_W +: CH_W] = is_rgb ? comp[(k+1) % NUM_CH] : comp[k];
  end

  assign pix_o = (in_col && in_row) ? pix_i : fill;
endmodule

// File: rtl/lbox_out_stage.sv
module lbox_out_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] in_data_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_data_o
);
  logic         vld_q;
  logic [W-1:0] dat_q;

  assign in_ready_o  = !vld_q || out_ready_i;
  assign out_valid_o = vld_q;
  assign out_data_o  = dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (in_ready_o) begin
      vld_q <= in_valid_i;
      if (in_valid_i) dat_q <= in_data_i;
    end
  end
endmodule

// File: rtl/lbox_mask.sv
module lbox_mask
  import lbox_pkg::*;
#(
  parameter int unsigned CH_W = 8,
  localparam int unsigned PIX_W = NUM_CH * CH_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             done_o,
  input  logic [CFG_W-1:0] frame_w_i,
  input  logic [CFG_W-1:0] frame_h_i,
  input  logic [CFG_W-1:0] fmt_i,
  input  logic [CFG_W-1:0] col_lo_i,
  input  logic [CFG_W-1:0] col_hi_i,
  input  logic [CFG_W-1:0] row_lo_i,
  input  logic [CFG_W-1:0] row_hi_i,
  input  logic [CFG_W-1:0] fill_a_i,
  input  logic [CFG_W-1:0] fill_b_i,
  input  logic [CFG_W-1:0] fill_c_i,
  input  logic [PIX_W-1:0] s_tdata_i,
  input  logic             s_tuser_i,
  input  logic             s_tlast_i,
  input  logic             s_tvalid_i,
  output logic             s_tready_o,
  output logic [PIX_W-1:0] m_tdata_o,
  output logic             m_tuser_o,
  output logic             m_tlast_o,
  output logic             m_tvalid_o,
  input  logic             m_tready_i
);
  localparam int unsigned BUS_W = PIX_W + 3;

  lbox_cfg_t        cfg_in, cfg_q;
  logic             busy_q, done_q, load, step, stage_ready, frame_end;
  logic [CFG_W-1:0] col, row;
  logic [PIX_W-1:0] pix_sel;
  logic [BUS_W-1:0] bus_in, bus_out;
  logic             out_final;

  assign cfg_in = '{width: frame_w_i, height: frame_h_i, fmt: fmt_i,
                    col_lo: col_lo_i, col_hi: col_hi_i,
                    row_lo: row_lo_i, row_hi: row_hi_i,
                    fill_a: fill_a_i, fill_b: fill_b_i, fill_c: fill_c_i};

  assign load       = start_i && !busy_q;
  assign s_tready_o = busy_q && stage_ready;
  assign step       = s_tvalid_i && s_tready_o;

  lbox_cfg_latch i_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .cfg_i  (cfg_in),
    .cfg_o  (cfg_q)
  );

  lbox_pos_ctr #(.DIM_W(CFG_W)) i_pos (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (step),
    .sof_i       (s_tuser_i),
    .eol_i       (s_tlast_i),
    .height_i    (cfg_q.height),
    .col_o       (col),
    .row_o       (row),
    .frame_end_o (frame_end)
  );

  lbox_pix_sel #(.CH_W(CH_W), .DIM_W(CFG_W)) i_sel (
    .cfg_i (cfg_q),
    .col_i (col),
    .row_i (row),
    .pix_i (s_tdata_i),
    .pix_o (pix_sel)
  );

  assign bus_in = {frame_end, s_tuser_i, s_tlast_i, pix_sel};

  lbox_out_stage #(.W(BUS_W)) i_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (s_tvalid_i && busy_q),
    .in_ready_o  (stage_ready),
    .in_data_i   (bus_in),
    .out_valid_o (m_tvalid_o),
    .out_ready_i (m_tready_i),
    .out_data_o  (bus_out)
  );

  assign {out_final, m_tuser_o, m_tlast_o, m_tdata_o} = bus_out;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (load) busy_q <= 1'b1;
      else if (step && frame_end) busy_q <= 1'b0;
      done_q <= m_tvalid_o && m_tready_i && out_final;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/lbox_mask_chk.sv
module lbox_mask_chk #(
  parameter int unsigned PIX_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             done_o,
  input logic             s_tvalid_i,
  input logic             s_tready_o,
  input logic [PIX_W-1:0] m_tdata_o,
  input logic             m_tuser_o,
  input logic             m_tlast_o,
  input logic             m_tvalid_o,
  input logic             m_tready_i
);
  a_r6_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tvalid_o && !m_tready_i |=> m_tvalid_o && $stable(m_tdata_o)
                                  && $stable(m_tuser_o) && $stable(m_tlast_o));

  a_r6_out_from_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(m_tvalid_o) |-> $past(s_tvalid_i && s_tready_o));

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(m_tvalid_o && m_tready_i && m_tlast_o));
endmodule

bind lbox_mask lbox_mask_chk #(.PIX_W(PIX_W)) i_lbox_mask_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .done_o     (done_o),
  .s_tvalid_i (s_tvalid_i),
  .s_tready_o (s_tready_o),
  .m_tdata_o  (m_tdata_o),
  .m_tuser_o  (m_tuser_o),
  .m_tlast_o  (m_tlast_o),
  .m_tvalid_o (m_tvalid_o),
  .m_tready_i (m_tready_i)
);

// File: tb/test_lbox_mask.sv
`timescale 1ns/100ps
module test_lbox_mask;
  logic        clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic        done_o;
  logic [15:0] frame_w_i, frame_h_i, fmt_i, col_lo_i, col_hi_i, row_lo_i, row_hi_i;
  logic [15:0] fill_a_i, fill_b_i, fill_c_i;
  logic [23:0] s_tdata_i = '0, m_tdata_o;
  logic        s_tuser_i = 1'b0, s_tlast_i = 1'b0, s_tvalid_i = 1'b0, s_tready_o;
  logic        m_tuser_o, m_tlast_o, m_tvalid_o, m_tready_i = 1'b1;

  int   n_chk = 0, n_bad = 0;
  bit   bp_en = 1'b0, ended = 1'b0, done_exp = 1'b0;
  logic [7:0] lfsr = 8'hA1;

  typedef struct { logic [23:0] d; logic u, l, f; string tag; } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  lbox_mask i_lbox_mask (.*, .clk_i(clk));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // backpressure source
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    m_tready_i <= bp_en ? lfsr[0] : 1'b1;
  end

  // monitor
  always @(negedge clk) begin
    #1;
    if (done_exp) chk(done_o == 1'b1, "R9 done pulse", 32'(done_o), 1);
    else if (done_o) chk(1'b0, "R9 stray done", 1, 0);
    done_exp = 1'b0;
    if (m_tvalid_o && m_tready_i && rst_ni) begin
      if (q.size() == 0) chk(1'b0, "R6 unexpected beat", 32'(m_tdata_o), 0);
      else begin
        item_t it;
        it = q.pop_front();
        chk(m_tdata_o == it.d, it.tag, 32'(m_tdata_o), 32'(it.d));
        chk({m_tuser_o, m_tlast_o} == {it.u, it.l}, "R6 sideband",
            32'({m_tuser_o, m_tlast_o}), 32'({it.u, it.l}));
        if (it.f) done_exp = 1'b1;
      end
    end
  end

  task automatic set_cfg(input logic [15:0] w, h, f, cl, ch, rl, rh);
    frame_w_i = w; frame_h_i = h; fmt_i = f;
    col_lo_i = cl; col_hi_i = ch; row_lo_i = rl; row_hi_i = rh;
    fill_a_i = 16'h1211; fill_b_i = 16'h3422; fill_c_i = 16'h5633;
  endtask

  // lines: beats sent; ppl: pixels per line; sof2: line with a second TUSER (-1 none)
  task automatic send_frame(input int lines, input int ppl, input int sof2, input bit midchg, input int fr);
    logic [15:0] w, h, f, cl, ch, rl, rh, fa, fb, fc;
    int col = 0, row = 0;
    @(negedge clk); #0.5 start_i = 1'b1;
    @(negedge clk); #0.5 start_i = 1'b0;
    w = frame_w_i; h = frame_h_i; f = fmt_i; cl = col_lo_i; ch = col_hi_i;
    rl = row_lo_i; rh = row_hi_i; fa = fill_a_i; fb = fill_b_i; fc = fill_c_i;
    for (int ln = 0; ln < lines; ln++) begin
      if (midchg && ln == 1) begin
        col_lo_i = 0; col_hi_i = 16'hffff; row_lo_i = 0; row_hi_i = 16'hffff;
        fill_a_i = 16'h00ee; fmt_i = ~f; frame_h_i = 16'd2;
      end
      for (int p = 0; p < ppl; p++) begin
        item_t it;
        logic [23:0] pix, fillv;
        bit keep;
        it.u = (p == 0) && (ln == 0 || ln == sof2);
        it.l = (p == ppl - 1);
        if (it.u) begin col = 0; row = 0; end
        pix = {ln[7:0] ^ 8'hA5, p[7:0], fr[7:0]};
        fillv = (f == 0) ? {fa[7:0], fc[7:0], fb[7:0]} : {fc[7:0], fb[7:0], fa[7:0]};
        keep = col >= int'(cl) && col < int'(ch) && col < int'(w) && row >= int'(rl) && row < int'(rh);
        it.d = keep ? pix : fillv;
        it.f = it.l && (row == int'(h) - 1);
        if (midchg && ln >= 1) it.tag = "R8 snapshot";
        else if (sof2 >= 0 && ln >= sof2) it.tag = "R7 sof restart";
        else if (keep) it.tag = "R3 keep";
        else if (cl >= ch || rl >= rh) it.tag = "R10 empty window";
        else if (col >= int'(w)) it.tag = "R11 beyond width R4";
        else if (f != 0) it.tag = "R5 ycc fill R4";
        else it.tag = "R4 rgb fill R5";
        q.push_back(it);
        s_tdata_i = pix; s_tuser_i = it.u; s_tlast_i = it.l; s_tvalid_i = 1'b1;
        while (!s_tready_o) begin @(negedge clk); #0.5; end
        @(posedge clk); @(negedge clk); #0.5;
        if (it.l) begin col = 0; row++; end else col++;
      end
    end
    s_tvalid_i = 1'b0; s_tuser_i = 1'b0; s_tlast_i = 1'b0;
    chk(s_tready_o == 1'b0, "R2 ready drops after frame", 32'(s_tready_o), 0);
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    #0.5;
  endtask

  initial begin
    set_cfg(8, 6, 0, 2, 6, 1, 4);
    repeat (3) @(negedge clk);
    #1;
    chk(m_tvalid_o == 0, "R1 valid", 32'(m_tvalid_o), 0);
    chk(s_tready_o == 0, "R1 ready", 32'(s_tready_o), 0);
    chk(done_o == 0, "R1 done", 32'(done_o), 0);
    rst_ni = 1'b1;
    s_tvalid_i = 1'b1; s_tdata_i = 24'h123456;
    repeat (4) @(negedge clk);
    #0.5;
    chk(s_tready_o == 0, "R2 not ready before start", 32'(s_tready_o), 0);
    chk(m_tvalid_o == 0, "R2 nothing taken before start", 32'(m_tvalid_o), 0);
    s_tvalid_i = 1'b0;
    send_frame(6, 8, -1, 0, 1);
    bp_en = 1'b1;
    set_cfg(8, 6, 1, 2, 6, 1, 4);
    send_frame(6, 8, -1, 0, 2);
    set_cfg(8, 4, 0, 5, 3, 2, 2);
    send_frame(4, 8, -1, 0, 3);
    set_cfg(4, 3, 1, 0, 10, 0, 10);
    send_frame(3, 6, -1, 0, 4);
    set_cfg(8, 6, 0, 2, 6, 1, 4);
    send_frame(6, 8, -1, 1, 5);
    set_cfg(6, 4, 1, 1, 5, 1, 3);
    send_frame(6, 6, 2, 0, 6);
    ended = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R9 act=0 exp=1");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule